// File: doc/BRIEF.md
# Serial Control-Register Target

This block is the device-side end of a five-wire serial control port (reset, serial clock, command line, serial data in, serial data out). It watches the command line for a four-bit start marker. Once it finds one, it decodes a fixed 32-bit frame: an operation code, a device identifier, a register address and, for writes, eight data bits. A write updates a small internal register file. A read returns the addressed register on the serial data output. Every line is sampled, and the output changes, on the falling edge of the serial clock.

Several targets can share the command line. Their data pins are chained: when a device read names another device, the target copies its serial data input straight to its output, so the addressed device's reply passes through. The target's own identifier lives in register 0. It is reset to zero and can be rewritten over the same port.

Frame bits are numbered 0 to 31. Bit k is the one sampled on the k-th falling edge of the frame, counted from 0 at the first start-marker bit. Fields are sent most significant bit first.

Top module: `serial_regport`

## Requirements
- R1: A frame begins only when the last four command-line bits sampled outside a frame are 1,1,0,0, with bit 0 first. While hunting for that marker, any other bit stream changes no register and never enables the output.
- R2: After the marker, the frame holds the following fields: bits 4–5 are the operation code; bits 6–7 must be zero; bits 8–13 are the identifier; bits 14–21 are the address; bit 22 must be zero; bits 23–30 are data; bit 31 must be zero. The operation codes are 00 device write, 01 broadcast write, 10 device read and 11 forced read.
- R3: A device write stores its data bits in the addressed register when the frame identifier equals the low six bits of register 0. When they differ, the write changes nothing.
- R4: A broadcast write stores its data whatever the frame identifier is.
- R5: A device read with a matching identifier raises `sdo_oe`. It then presents the register's eight bits on `sdo`, most significant bit first. Each bit is valid after falling edge 22+i and is sampled on edge 23+i, for i from 0 to 7. `sdo_oe` is high exactly from after edge 22 until edge 30.
- R6: A device read with a non-matching identifier raises `sdo_oe` for the same window, and during that window `sdo` equals `sdi`.
- R7: A forced read returns the addressed register in the R5 window whatever the frame identifier is.
- R8: Register 0 holds the identifier. It resets to zero and is written like any other register.
- R9: A write to an address at or above the register count is ignored. A read of such an address returns zero.
- R10: A frame with a one in bit 6, 7, 22 or 31 writes no register. If the fault lies in bits 6, 7 or 22, the frame also never raises `sdo_oe`.
- R11: Reset clears every register and holds `sdo` and `sdo_oe` low.
- R12: Write frames never raise `sdo_oe`.
- R13: Frames may follow one another with no gap, and the serial clock may stop between frames without any loss of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock; all sampling is on its falling edge |
| rst | input | 1 | Asynchronous active-high reset |
| cmd | input | 1 | Command line carrying the frame |
| sdi | input | 1 | Serial data from the next device in the chain |
| sdo | output | 1 | Serial read data or forwarded `sdi` |
| sdo_oe | output | 1 | High while `sdo` carries read or forwarded data |

## Verification
The assertions assume that `cmd` and `sdi` are stable around each falling edge of `sck`. They also assume that `sck` stops only while high and only between frames. The bench changes its inputs on rising edges and gates the clock only right after a rising edge, at a frame boundary. It models the register file itself and compares every read with that model, covering each address, matching and non-matching identifiers, corrupted zero bits and noise before a start marker.

// File: rtl/serial_regport.sv
module serial_regport #(
  parameter int NREG = 16
) (
  input  logic sck,
  input  logic rst,
  input  logic cmd,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [4:0] B_OP  = 5'd5;
  localparam logic [4:0] B_ID  = 5'd13;
  localparam logic [4:0] B_ADR = 5'd21;
  localparam logic [4:0] B_GAP = 5'd22;
  localparam logic [4:0] B_DAT = 5'd30;
  localparam logic [4:0] B_END = 5'd31;

  logic       active, bad, drv, fwd;
  logic [4:0] cnt;
  logic [2:0] hunt;
  logic [7:0] sr, adr, wd, ob;
  logic [1:0] op;
  logic [5:0] sid;
  logic [7:0] regs [NREG];

  wire [7:0] sr_n     = {sr[6:0], cmd};
  wire       hit      = (sid == regs[0][5:0]);
  wire       inrange  = int'(adr) < NREG;
  wire [7:0] rdval    = inrange ? regs[adr[AW-1:0]] : 8'd0;
  wire       start_ok = !active && ({hunt, cmd} == 4'b1100);
  wire       go_read  = op[1] && (op[0] || hit);
  wire       go_fwd   = (op == 2'b10) && !hit;
  wire       wr_ok    = !op[1] && (op[0] || hit) && !bad && !cmd && inrange;

  assign sdo_oe = drv | fwd;
  assign sdo    = fwd ? sdi : (drv & ob[7]);

  always_ff @(negedge sck or posedge rst) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      hunt   <= '0;
      sr     <= '0;
      op     <= '0;
      sid    <= '0;
      adr    <= '0;
      wd     <= '0;
      bad    <= 1'b0;
      drv    <= 1'b0;
      fwd    <= 1'b0;
      ob     <= '0;
    end else if (!active) begin
      hunt <= {hunt[1:0], cmd};
      if (start_ok) begin
        active <= 1'b1;
        cnt    <= 5'd4;
        bad    <= 1'b0;
      end
    end else begin
      cnt <= cnt + 5'd1;
      sr  <= sr_n;
      if (drv) ob <= {ob[6:0], 1'b0};
      case (cnt)
        B_OP:        op  <= sr_n[1:0];
        5'd6, 5'd7:  if (cmd) bad <= 1'b1;
        B_ID:        sid <= sr_n[5:0];
        B_ADR:       adr <= sr_n;
        B_GAP: begin
          if (cmd || bad) bad <= 1'b1;
          else if (go_read) begin
            drv <= 1'b1;
            ob  <= rdval;
          end else if (go_fwd) fwd <= 1'b1;
        end
        B_DAT: begin
          wd  <= sr_n;
          drv <= 1'b0;
          fwd <= 1'b0;
        end
        B_END: begin
          active <= 1'b0;
          hunt   <= '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge sck or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (active && cnt == B_END && wr_ok) begin
      regs[adr[AW-1:0]] <= wd;
    end
  end

  assert_single_mode_R6: assert property (@(negedge sck) disable iff (rst)
    $onehot0({drv, fwd}));

  assert_window_open_R5: assert property (@(negedge sck) disable iff (rst)
    ($rose(drv) || $rose(fwd)) |-> (cnt == 5'd23));

  assert_window_close_R5: assert property (@(negedge sck) disable iff (rst)
    ($fell(drv) || $fell(fwd)) |-> (cnt == 5'd31));

  assert_id_write_at_end_R8: assert property (@(negedge sck) disable iff (rst)
    !$stable(regs[0]) |-> ($past(active) && $past(cnt) == B_END));

  assert_no_drive_outside_frame_R1: assert property (@(negedge sck) disable iff (rst)
    !active |-> !sdo_oe);
endmodule

// File: tb/serial_regport_test.sv
module serial_regport_test;
  localparam int NREG = 16;
  logic sck = 1'b1, sck_en = 1'b1;
  logic rst, cmd, sdi;
  logic sdo, sdo_oe;
  int errors = 0, checks = 0;
  logic [7:0] model [NREG];
  localparam logic [31:0] WIN = 32'h7F80_0000;

  serial_regport #(.NREG(NREG)) uut (.sck(sck), .rst(rst), .cmd(cmd), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe));

  always #5 if (sck_en) sck = ~sck;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [5:0] id,
                                     input logic [7:0] a, input logic [7:0] d);
    return {4'b1100, op, 2'b00, id, a, 1'b0, d, 1'b0};
  endfunction

  task automatic frame(input logic [31:0] f, input logic [7:0] pat,
                       output logic [7:0] got, output logic [31:0] om);
    got = '0; om = '0;
    for (int k = 0; k < 32; k++) begin
      @(posedge sck);
      cmd = f[31-k];
      sdi = (k >= 23 && k <= 30) ? pat[30-k] : k[0];
      #1;
      om[k] = sdo_oe;
      if (k >= 23 && k <= 30) got[30-k] = sdo;
    end
  endtask

  task automatic wr(input logic [1:0] op, input logic [5:0] id, input logic [7:0] a,
                    input logic [7:0] d, input string req);
    logic [7:0] g; logic [31:0] om;
    frame(mk(op, id, a, d), 8'h00, g, om);
    chk(om == 0, {req, " R12 write oe"}, om, 0);
  endtask

  task automatic rd(input logic [1:0] op, input logic [5:0] id, input logic [7:0] a,
                    input logic [7:0] pat, output logic [7:0] g, output logic [31:0] om);
    frame(mk(op, id, a, 8'h00), pat, g, om);
  endtask

  task automatic sweep(input string req);
    logic [7:0] g; logic [31:0] om;
    for (int a = 0; a < NREG; a++) begin
      rd(2'b11, 6'h3F, 8'(a), 8'h00, g, om);
      chk(g == model[a], req, g, model[a]);
    end
  endtask

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] g; logic [31:0] om;
    logic [31:0] f;
    rst = 1'b1; cmd = 1'b0; sdi = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (4) @(posedge sck);
    #1;
    chk(sdo_oe == 0 && sdo == 0, "R11 reset outputs", {sdo_oe, sdo}, 0);
    rst = 1'b0;
    sweep("R11 R7 reset registers");

    for (int a = 1; a < NREG; a++) begin
      model[a] = 8'(a * 37 + 5);
      wr(2'b00, 6'h00, 8'(a), model[a], "R3");
    end
    for (int a = 1; a < NREG; a++) begin
      rd(2'b10, 6'h00, 8'(a), 8'hFF, g, om);
      chk(g == model[a], "R3 R5 readback", g, model[a]);
      chk(om == WIN, "R5 oe window", om, WIN);
    end

    wr(2'b00, 6'h00, 8'd16, 8'hA5, "R9");
    wr(2'b01, 6'h00, 8'd128, 8'hA5, "R9");
    wr(2'b00, 6'h00, 8'd255, 8'hA5, "R9");
    rd(2'b11, 6'h00, 8'd255, 8'h00, g, om);
    chk(g == 0, "R9 out-of-range read", g, 0);
    sweep("R9 no aliasing");

    model[0] = 8'h2A;
    wr(2'b00, 6'h00, 8'd0, 8'h2A, "R8");
    wr(2'b00, 6'h00, 8'd3, 8'h11, "R3 mismatch");
    rd(2'b10, 6'h2A, 8'd3, 8'h00, g, om);
    chk(g == model[3], "R3 mismatched write ignored", g, model[3]);
    rd(2'b10, 6'h2A, 8'd0, 8'h00, g, om);
    chk(g == 8'h2A, "R8 id register", g, 8'h2A);
    rd(2'b11, 6'h07, 8'd3, 8'h00, g, om);
    chk(g == model[3] && om == WIN, "R7 forced read", g, model[3]);

    model[4] = 8'hC3;
    wr(2'b01, 6'h05, 8'd4, 8'hC3, "R4");
    rd(2'b10, 6'h2A, 8'd4, 8'h00, g, om);
    chk(g == 8'hC3, "R4 broadcast write", g, 8'hC3);

    rd(2'b10, 6'h01, 8'd4, 8'h96, g, om);
    chk(g == 8'h96, "R6 forward data", g, 8'h96);
    chk(om == WIN, "R6 forward window", om, WIN);
    rd(2'b10, 6'h00, 8'd4, 8'h3C, g, om);
    chk(g == 8'h3C, "R6 forward data 2", g, 8'h3C);

    frame(32'hFFFF_FFFF, 8'h00, g, om);
    chk(om == 0, "R1 noise no drive", om, 0);
    for (int k = 0; k < 4; k++) begin
      @(posedge sck); cmd = k != 1; sdi = 1'b0;
    end
    model[5] = 8'h77;
    wr(2'b00, 6'h2A, 8'd5, 8'h77, "R1");
    rd(2'b10, 6'h2A, 8'd5, 8'h00, g, om);
    chk(g == 8'h77, "R1 hunted start", g, 8'h77);

    f = mk(2'b00, 6'h2A, 8'd6, 8'h5A); f[25] = 1'b1;
    frame(f, 8'h00, g, om);
    f = mk(2'b00, 6'h2A, 8'd6, 8'h5A); f[0] = 1'b1;
    frame(f, 8'h00, g, om);
    f = mk(2'b01, 6'h2A, 8'd6, 8'h5A); f[9] = 1'b1;
    frame(f, 8'h00, g, om);
    f = mk(2'b11, 6'h2A, 8'd6, 8'h00); f[9] = 1'b1;
    frame(f, 8'h00, g, om);
    chk(om == 0, "R10 bad gap no drive", om, 0);
    f = mk(2'b11, 6'h2A, 8'd6, 8'h00); f[24] = 1'b1;
    frame(f, 8'h00, g, om);
    chk(om == 0, "R10 bad bit7 no drive", om, 0);
    rd(2'b10, 6'h2A, 8'd6, 8'h00, g, om);
    chk(g == model[6], "R10 discarded writes", g, model[6]);

    @(posedge sck);
    sck_en = 1'b0;
    #300;
    sck_en = 1'b1;
    sweep("R13 R2 state after clock stop");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule